// File: doc/BRIEF.md
# Prediction Smoothing and Reconstruction Stage

This block finishes the reconstruction of one 8x8 picture block in a motion-compensated video decoder. It receives the prediction pixels fetched from the previous picture and the signed residual pixels from the inverse transform. Both arrive together, one pair per cycle, in raster order. After all 64 pairs have arrived, the block optionally smooths the prediction with a separable three-tap low-pass kernel. It then adds the residual, or adds the residual to zero for intra-coded blocks, and saturates each result to an unsigned 8-bit pixel.

The whole block is held internally, so the vertical part of the kernel can see the rows above and below each pixel. Pixels on the outer rows are not smoothed vertically, and pixels on the outer columns are not smoothed horizontally. Results leave as a raster stream with a valid strobe, followed by a one-cycle completion pulse. The input is closed while a block is being emitted.

Top module: `mc_filter_recon`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, while `out_valid` and `out_done` are 0.
- R2: A block is 64 accepted input cycles (`in_valid` and `in_ready` both 1), in raster order: index = row*8 + column. Each cycle carries one prediction pixel and one residual pixel. The smoothing-enable and inter bits are taken from the first accepted cycle of the block; their values on the other 63 cycles have no effect.
- R3: With smoothing off and inter set to 1, each output equals clip(prediction + residual). The residual is a 9-bit two's-complement value.
- R4: With inter set to 0, each output equals clip(residual). The prediction and the smoothing setting have no effect.
- R5: With smoothing on, an interior pixel (row and column both in 1..6) uses the prediction (sum over the 3x3 neighbourhood with weights 1 2 1 / 2 4 2 / 1 2 1, plus 8) shifted right by 4.
- R6: With smoothing on, the prediction is smoothed in one direction only for some pixels. On row 0 or row 7 with an interior column, it is (left + 2*centre + right + 2) >> 2. On column 0 or column 7 with an interior row, it is (above + 2*centre + below + 2) >> 2. The four corner pixels pass through unchanged.
- R7: A sum above 255 gives 255, and a negative sum gives 0.
- R8: The 64 results are emitted in raster order, on 64 consecutive cycles. The first result is valid after the second rising edge that follows the edge accepting the 64th input.
- R9: `out_done` is high for exactly one cycle, the cycle right after the last result. `in_ready` is 0 from the edge that accepts the 64th input until that same edge, and it is never 1 while `out_valid` is 1.
- R10: `in_valid` has no effect while `in_ready` is 0. The results of the current block and of the next block are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block is accepting input |
| in_pred | input | 8 | Prediction pixel, unsigned |
| in_res | input | 9 | Residual pixel, two's complement |
| in_filt_en | input | 1 | Smoothing enable (sampled on the first pixel) |
| in_inter | input | 1 | 1 = add the prediction, 0 = intra (sampled on the first pixel) |
| out_valid | output | 1 | Result pixel valid |
| out_pix | output | 8 | Reconstructed pixel |
| out_done | output | 1 | One-cycle pulse after the 64th result |

## Verification
Every timing rule is counted from E, the rising edge that accepts the 64th input:
- `in_ready` falls at E.
- Result n is due after edge E+2+n.
- `out_done` is due after edge E+66, together with the rise of `in_ready`.

The bench keeps a cycle counter that starts at E and samples on the falling edge of every following cycle. At each sample it compares `out_valid`, `out_pix`, `out_done` and `in_ready` against values that a behavioural model derives from that counter. Any early, late or missing strobe is therefore reported at the exact cycle where it goes wrong.

// File: rtl/mc_filter_recon_pkg.sv
package mc_filter_recon_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } mfr_state_e;

  localparam int WIN_TAPS = 9;

endpackage

// File: rtl/mfr_block_store.sv
// Block buffer: one write port, NRD asynchronous read ports.
module mfr_block_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [WIDTH-1:0]          wr_data,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end

endmodule

// File: rtl/mfr_smooth3x3.sv
// Separable 1-2-1 smoothing with per-direction pass-through at block edges.
// Both directions are always scaled by 4 so one rounding step serves every case.
module mfr_smooth3x3 #(
  parameter int PIX_W = 8,
  localparam int VW   = PIX_W + 2,
  localparam int HW   = PIX_W + 4,
  localparam int SW   = PIX_W + 5
) (
  input  logic [8:0][PIX_W-1:0] win,      // index = 3*row_offset + col_offset
  input  logic                  row_edge,
  input  logic                  col_edge,
  input  logic                  enable,
  output logic [PIX_W-1:0]      pix_out
);

  logic [2:0][VW-1:0] vsum;
  logic [HW-1:0]      hsum;
  logic [SW-1:0]      rounded;

  for (genvar c = 0; c < 3; c++) begin : g_col
    assign vsum[c] = row_edge ? {win[3+c], 2'b00}
                              : VW'(win[c]) + VW'({win[3+c], 1'b0}) + VW'(win[6+c]);
  end

  assign hsum    = col_edge ? {vsum[1], 2'b00}
                            : HW'(vsum[0]) + HW'({vsum[1], 1'b0}) + HW'(vsum[2]);
  assign rounded = SW'(hsum) + SW'(8);
  assign pix_out = enable ? PIX_W'(rounded >> 4) : win[4];

endmodule

// File: rtl/mfr_recon_clip.sv
// Registered residual adder with saturation to the unsigned pixel range.
module mfr_recon_clip #(
  parameter int PIX_W = 8,
  parameter int RES_W = 9,
  localparam int SUM_W = ((RES_W > PIX_W) ? RES_W : PIX_W + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             inter,
  input  logic [PIX_W-1:0] pred,
  input  logic [RES_W-1:0] res,
  output logic             out_valid,
  output logic             out_last,
  output logic [PIX_W-1:0] out_pix
);

  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] pred_s, res_s, sum;
  logic [PIX_W-1:0]        clipped;

  always_comb begin
    pred_s = inter ? SUM_W'(pred) : '0;
    res_s  = {{(SUM_W-RES_W){res[RES_W-1]}}, res};
    sum    = pred_s + res_s;
    if (sum[SUM_W-1])   clipped = '0;
    else if (sum > MAXV) clipped = '1;
    else                 clipped = sum[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid & in_last;
      if (in_valid) out_pix <= clipped;
    end
  end

endmodule

// File: rtl/mc_filter_recon.sv
module mc_filter_recon #(
  parameter int BLK_DIM = 8,
  parameter int PIX_W   = 8,
  parameter int RES_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pred,
  input  logic [RES_W-1:0] in_res,
  input  logic             in_filt_en,
  input  logic             in_inter,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_done
);
  import mc_filter_recon_pkg::*;

  localparam int NPIX  = BLK_DIM * BLK_DIM;
  localparam int IDX_W = $clog2(NPIX);
  localparam int CRD_W = $clog2(BLK_DIM);
  localparam logic [CRD_W-1:0] LAST_CRD = CRD_W'(BLK_DIM - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  mfr_state_e       state;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             filt_q, inter_q;
  logic             accept;

  assign in_ready = (state == ST_LOAD);
  assign accept   = in_valid & in_ready;

  // Neighbourhood addressing, clamped at the edges.
  logic [CRD_W-1:0] rd_row, rd_col;
  logic [CRD_W-1:0] nb_row [3];
  logic [CRD_W-1:0] nb_col [3];
  logic             row_edge, col_edge;

  assign rd_row   = rd_idx[IDX_W-1:CRD_W];
  assign rd_col   = rd_idx[CRD_W-1:0];
  assign row_edge = (rd_row == '0) || (rd_row == LAST_CRD);
  assign col_edge = (rd_col == '0) || (rd_col == LAST_CRD);

  always_comb begin
    nb_row[0] = (rd_row == '0)      ? rd_row : rd_row - 1'b1;
    nb_row[1] = rd_row;
    nb_row[2] = (rd_row == LAST_CRD) ? rd_row : rd_row + 1'b1;
    nb_col[0] = (rd_col == '0)      ? rd_col : rd_col - 1'b1;
    nb_col[1] = rd_col;
    nb_col[2] = (rd_col == LAST_CRD) ? rd_col : rd_col + 1'b1;
  end

  logic [WIN_TAPS-1:0][IDX_W-1:0] win_addr;
  logic [WIN_TAPS-1:0][PIX_W-1:0] win_pix;

  for (genvar dr = 0; dr < 3; dr++) begin : g_wr
    for (genvar dc = 0; dc < 3; dc++) begin : g_wc
      assign win_addr[dr*3+dc] = {nb_row[dr], nb_col[dc]};
    end
  end

  mfr_block_store #(.DEPTH(NPIX), .WIDTH(PIX_W), .NRD(WIN_TAPS)) u_pred_store (
    .clk(clk), .wr_en(accept), .wr_addr(wr_idx), .wr_data(in_pred),
    .rd_addr(win_addr), .rd_data(win_pix)
  );

  logic [0:0][IDX_W-1:0] res_addr;
  logic [0:0][RES_W-1:0] res_rd;
  assign res_addr[0] = rd_idx;

  mfr_block_store #(.DEPTH(NPIX), .WIDTH(RES_W), .NRD(1)) u_res_store (
    .clk(clk), .wr_en(accept), .wr_addr(wr_idx), .wr_data(in_res),
    .rd_addr(res_addr), .rd_data(res_rd)
  );

  logic [PIX_W-1:0] smooth_pix;

  mfr_smooth3x3 #(.PIX_W(PIX_W)) u_smooth (
    .win(win_pix), .row_edge(row_edge), .col_edge(col_edge),
    .enable(filt_q), .pix_out(smooth_pix)
  );

  // Stage 1: registered prediction and residual.
  logic             s1_valid, s1_last;
  logic [PIX_W-1:0] s1_pred;
  logic [RES_W-1:0] s1_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_pred  <= '0;
      s1_res   <= '0;
    end else begin
      s1_valid <= (state == ST_RUN);
      s1_last  <= (state == ST_RUN) && (rd_idx == LAST_IDX);
      s1_pred  <= smooth_pix;
      s1_res   <= res_rd[0];
    end
  end

  logic rc_last;

  mfr_recon_clip #(.PIX_W(PIX_W), .RES_W(RES_W)) u_recon (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_last(s1_last),
    .inter(inter_q), .pred(s1_pred), .res(s1_res),
    .out_valid(out_valid), .out_last(rc_last), .out_pix(out_pix)
  );

  // Sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      wr_idx   <= '0;
      rd_idx   <= '0;
      filt_q   <= 1'b0;
      inter_q  <= 1'b0;
      out_done <= 1'b0;
    end else begin
      out_done <= 1'b0;
      unique case (state)
        ST_LOAD: if (accept) begin
          if (wr_idx == '0) begin
            filt_q  <= in_filt_en;
            inter_q <= in_inter;
          end
          if (wr_idx == LAST_IDX) begin
            state  <= ST_RUN;
            wr_idx <= '0;
            rd_idx <= '0;
          end else begin
            wr_idx <= wr_idx + 1'b1;
          end
        end
        ST_RUN: begin
          if (rd_idx == LAST_IDX) state <= ST_DRAIN;
          else                     rd_idx <= rd_idx + 1'b1;
        end
        ST_DRAIN: if (out_valid && rc_last) begin
          state    <= ST_LOAD;
          rd_idx   <= '0;
          out_done <= 1'b1;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/mc_filter_recon_chk.sv
module mc_filter_recon_chk #(
  parameter int NPIX = 64,
  localparam int CW  = $clog2(NPIX) + 1
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_done
);

  logic [CW-1:0] acc_cnt, out_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt <= '0;
      out_cnt <= '0;
    end else begin
      if (in_valid && in_ready)
        acc_cnt <= (acc_cnt == CW'(NPIX)) ? CW'(1) : acc_cnt + 1'b1;
      if (out_done)       out_cnt <= '0;
      else if (out_valid) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R2: the input closes only after a full block has been accepted
  assert_full_block_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> (acc_cnt == CW'(NPIX)));

  // R8: exactly one block's worth of results precedes completion
  assert_out_count_R8: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_cnt == CW'(NPIX)));

  // R9: input and output phases never overlap
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R9: completion follows the final result directly
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    out_done |-> ($past(out_valid) && !out_valid));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

endmodule

bind mc_filter_recon mc_filter_recon_chk #(.NPIX(BLK_DIM*BLK_DIM)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_done(out_done)
);

// File: tb/mc_filter_recon_bench.sv
module mc_filter_recon_bench;
  localparam int NP = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_filt_en = 1'b0;
  logic       in_inter = 1'b0;
  logic [7:0] in_pred = '0;
  logic [8:0] in_res = '0;
  logic       in_ready, out_valid, out_done;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  int pv [NP];
  int rv [NP];
  int ev [NP];

  always #10 clk = ~clk;

  mc_filter_recon u_mc_filter_recon (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pred(in_pred), .in_res(in_res), .in_filt_en(in_filt_en),
    .in_inter(in_inter), .out_valid(out_valid), .out_pix(out_pix),
    .out_done(out_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int p(input int r, input int c);
    return pv[r*8+c];
  endfunction

  function automatic int clip8(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // Prediction after optional smoothing, per the case split of R5 and R6.
  function automatic int smoothed(input int r, input int c, input bit fen);
    bit re, ce;
    if (!fen) return p(r, c);
    re = (r == 0) || (r == 7);
    ce = (c == 0) || (c == 7);
    if (re && ce) return p(r, c);
    if (re) return (p(r, c-1) + 2*p(r, c) + p(r, c+1) + 2) / 4;
    if (ce) return (p(r-1, c) + 2*p(r, c) + p(r+1, c) + 2) / 4;
    return (p(r-1, c-1) + 2*p(r-1, c) + p(r-1, c+1)
          + 2*p(r, c-1) + 4*p(r, c) + 2*p(r, c+1)
          + p(r+1, c-1) + 2*p(r+1, c) + p(r+1, c+1) + 8) / 16;
  endfunction

  task automatic drive_garbage();
    in_valid   = 1'b1;
    in_pred    = 8'($urandom);
    in_res     = 9'($urandom);
    in_filt_en = 1'($urandom);
    in_inter   = 1'($urandom);
  endtask

  task automatic run_block(input bit fen, input bit inter, input bit flip,
                           input bit garbage, input string tag);
    for (int i = 0; i < NP; i++)
      ev[i] = clip8((inter ? smoothed(i/8, i%8, fen) : 0) + rv[i]);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_pred    = 8'(pv[i]);
      in_res     = 9'(rv[i]);
      in_filt_en = (flip && i > 0) ? !fen : fen;
      in_inter   = (flip && i > 0) ? !inter : inter;
      @(posedge clk);
    end
    @(negedge clk);
    check(in_ready == 1'b0, "R9", "in_ready after last input", int'(in_ready), 0);
    check(out_valid == 1'b0, "R8", "out_valid after last input", int'(out_valid), 0);
    if (garbage) drive_garbage(); else in_valid = 1'b0;
    for (int k = 1; k <= 67; k++) begin
      bit ev_valid;
      @(posedge clk);
      @(negedge clk);
      ev_valid = (k >= 2) && (k <= 65);
      check(out_valid == ev_valid, "R8", $sformatf("out_valid k=%0d", k),
            int'(out_valid), int'(ev_valid));
      if (ev_valid && out_valid)
        check(int'(out_pix) == ev[k-2], tag, $sformatf("pixel %0d", k-2),
              int'(out_pix), ev[k-2]);
      check(out_done == (k == 66), "R9", $sformatf("out_done k=%0d", k),
            int'(out_done), int'(k == 66));
      check(in_ready == (k >= 66), "R9", $sformatf("in_ready k=%0d", k),
            int'(in_ready), int'(k >= 66));
      if (garbage && k < 63) drive_garbage(); else in_valid = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_done == 1'b0, "R1", "out_done after reset", int'(out_done), 0);

    // R3: plain inter add
    for (int i = 0; i < NP; i++) begin
      pv[i] = $urandom_range(255);
      rv[i] = $urandom_range(80) - 40;
    end
    run_block(1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // R4: intra ignores prediction and smoothing setting
    for (int i = 0; i < NP; i++) begin
      pv[i] = $urandom_range(255);
      rv[i] = $urandom_range(511) - 256;
    end
    run_block(1'b0, 1'b0, 1'b0, 1'b0, "R4");
    run_block(1'b1, 1'b0, 1'b0, 1'b0, "R4");

    // R5, R6: smoothing on random prediction with zero residual
    for (int i = 0; i < NP; i++) begin
      pv[i] = $urandom_range(255);
      rv[i] = 0;
    end
    run_block(1'b1, 1'b1, 1'b0, 1'b0, "R5,R6");

    // R6: checkerboard stresses rounding on edges and corners
    for (int i = 0; i < NP; i++) begin
      pv[i] = (((i/8) + (i%8)) % 2) ? 255 : 0;
      rv[i] = 0;
    end
    run_block(1'b1, 1'b1, 1'b0, 1'b0, "R6");

    // R7: saturation at both ends
    for (int i = 0; i < NP; i++) begin
      case (i % 4)
        0: begin pv[i] = 250; rv[i] = 200;  end
        1: begin pv[i] = 5;   rv[i] = -200; end
        2: begin pv[i] = 255; rv[i] = 0;    end
        default: begin pv[i] = 255; rv[i] = -256; end
      endcase
    end
    run_block(1'b0, 1'b1, 1'b0, 1'b0, "R7");

    // R2: mode bits on later pixels are ignored
    for (int i = 0; i < NP; i++) begin
      pv[i] = $urandom_range(255);
      rv[i] = $urandom_range(60) - 30;
    end
    run_block(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    run_block(1'b0, 1'b1, 1'b1, 1'b0, "R2");

    // R10: input activity while closed is ignored, this block and the next
    run_block(1'b0, 1'b1, 1'b0, 1'b1, "R10");
    for (int i = 0; i < NP; i++) begin
      pv[i] = $urandom_range(255);
      rv[i] = $urandom_range(511) - 256;
    end
    run_block(1'b1, 1'b1, 1'b0, 1'b1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule